// File: doc/BRIEF.md
# Thread Interrupt Priority Presenter

This block holds the interrupt presentation context of one hardware thread at the operating-system level. It keeps four 8-bit values: a one-hot map of pending priorities, the most favoured pending priority derived from that map, the thread's current priority threshold, and a status byte whose top bit records that an exception is being signalled. Numerically smaller priorities are more favoured. Priorities 0 to 7 are valid.

Events arrive in three ways. A notify input carries a priority. A write port either replaces the current threshold or posts a pending priority. An acknowledge request takes the presented interrupt. Whenever an event or a threshold write lands, the block compares the favoured pending priority with the threshold and raises a level interrupt toward the processor if the pending one is strictly more favoured. An acknowledge drops the interrupt line. If an exception was being signalled, the acknowledge also moves the favoured priority into the threshold, retires that pending bit and clears the exception flag. The acknowledge answer is a 16-bit word that returns the old status and the new threshold.

Top module: `thread_prio_presenter`

## Requirements
- R1: After a synchronous reset the pending map is 0x00, the favoured priority is 0xFF, the threshold is 0x00, the status byte is 0x00, and `irq_o` and `ack_valid_o` are low.
- R2: A priority p in 0..7 maps to pending-map bit (7 − p), so priority 0 is bit 7. A priority value of 8 or more sets no bit.
- R3: The favoured priority equals the number of leading zeros of the 8-bit pending map, counted from bit 7. It is 0xFF when the map is empty.
- R4: A notify (`evt_valid_i` with `evt_prio_i`) and a set-pending write (`wr_valid_i` with `wr_sel_i`=1, priority taken from `wr_data_i[7:0]` only) both OR their bit into the pending map and then run the exception check. Both may occur in one cycle.
- R5: The exception check sets status bit 7 and drives `irq_o` high only if the favoured priority is strictly less than the threshold. It never clears either of them.
- R6: A threshold write (`wr_valid_i` with `wr_sel_i`=0) stores `wr_data_i[7:0]` as the threshold and runs the exception check, so a less restrictive threshold can raise a waiting interrupt.
- R7: An acknowledge always lowers `irq_o`. If status bit 7 is set, it copies the favoured priority into the threshold, clears that priority's pending bit, recomputes the favoured priority and clears status bit 7. If status bit 7 is clear, the state is left unchanged.
- R8: One cycle after `ack_req_i`, `ack_valid_o` pulses. `ack_data_o[15:8]` then holds the status byte from before the acknowledge, and `ack_data_o[7:0]` holds the threshold as it stands after the acknowledge step.
- R9: When an acknowledge coincides with a notify, set-pending or threshold write, the acknowledge is applied first and the other updates afterwards. All updates become visible after one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid_i | input | 1 | Notify strobe |
| evt_prio_i | input | 8 | Notify priority |
| wr_valid_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = threshold write, 1 = set-pending write |
| wr_data_i | input | WDATA_W (32) | Write data; only bits [7:0] are used |
| ack_req_i | input | 1 | Acknowledge request |
| ack_valid_o | output | 1 | Acknowledge answer valid |
| ack_data_o | output | 16 | {old status, new threshold} |
| irq_o | output | 1 | Level interrupt to the processor |
| pend_map_o | output | 8 | Pending-priority map |
| best_prio_o | output | 8 | Favoured pending priority |
| cur_prio_o | output | 8 | Current threshold |
| status_o | output | 8 | Status byte; bit 7 is the exception flag |

## Verification
A single notify is tested against thresholds above, equal to and below its priority. This shows that the comparison is strict and that a later threshold write can raise a waiting interrupt. Acknowledges are issued both with and without an active exception, which separates the promote-and-retire path from the plain line drop. Out-of-range priorities and set-pending data with non-zero upper bits show that only valid low-byte priorities reach the map. Acknowledges that share a cycle with notifies and threshold writes test the ordering, because the returned threshold and the final map differ depending on which update is applied first.

// File: rtl/tpp_pkg.sv
package tpp_pkg;

    localparam int CTX_W   = 8;
    localparam int NPRIO   = 8;
    localparam int EXC_BIT = 7;
    localparam int ACK_W   = 2 * CTX_W;

    localparam logic [CTX_W-1:0] NO_PRIO = '1;

    typedef logic [CTX_W-1:0] ctx_byte_t;

    typedef enum logic {
        WSEL_THRESH = 1'b0,
        WSEL_POST   = 1'b1
    } wsel_e;

    typedef struct packed {
        ctx_byte_t pend;
        ctx_byte_t best;
        ctx_byte_t cur;
        ctx_byte_t status;
    } ctx_t;

    function automatic ctx_byte_t exc_mask();
        ctx_byte_t m;
        m = '0;
        m[EXC_BIT] = 1'b1;
        return m;
    endfunction

    function automatic ctx_t ctx_reset_value();
        ctx_t c;
        c.pend   = '0;
        c.best   = NO_PRIO;
        c.cur    = '0;
        c.status = '0;
        return c;
    endfunction

endpackage

// File: rtl/tpp_prio_decode.sv
module tpp_prio_decode
    import tpp_pkg::*;
#(
    parameter int N = NPRIO
) (
    input  logic             en_i,
    input  logic [CTX_W-1:0] prio_i,
    output logic [N-1:0]     bits_o
);

    // Bit (N-1-p) stands for priority p; values at or above N match no bit.
    for (genvar g = 0; g < N; g++) begin : g_bit
        localparam logic [CTX_W-1:0] PRIO_OF_BIT = CTX_W'(N - 1 - g);
        assign bits_o[g] = en_i && (prio_i == PRIO_OF_BIT);
    end

endmodule

// File: rtl/tpp_lead_zero.sv
module tpp_lead_zero
    import tpp_pkg::*;
#(
    parameter int N = NPRIO
) (
    input  logic [N-1:0]     map_i,
    output logic [CTX_W-1:0] best_o
);

    // The highest set bit wins, so the loop runs upward and the last hit stays.
    always_comb begin
        best_o = NO_PRIO;
        for (int i = 0; i < N; i++) begin
            if (map_i[i]) begin
                best_o = CTX_W'(N - 1 - i);
            end
        end
    end

endmodule

// File: rtl/tpp_ack_stage.sv
module tpp_ack_stage
    import tpp_pkg::*;
(
    input  ctx_t             ctx_i,
    input  logic             ack_i,
    output ctx_t             ctx_o,
    output logic [ACK_W-1:0] word_o
);

    logic             take;
    logic [NPRIO-1:0] retire_bits;
    logic [NPRIO-1:0] pend_left;
    logic [CTX_W-1:0] best_left;

    assign take = ack_i && ctx_i.status[EXC_BIT];

    tpp_prio_decode #(.N(NPRIO)) u_retire (
        .en_i   (take),
        .prio_i (ctx_i.best),
        .bits_o (retire_bits)
    );

    assign pend_left = ctx_i.pend & ~retire_bits;

    tpp_lead_zero #(.N(NPRIO)) u_rescan (
        .map_i  (pend_left),
        .best_o (best_left)
    );

    always_comb begin
        ctx_o = ctx_i;
        if (take) begin
            ctx_o.cur    = ctx_i.best;
            ctx_o.pend   = pend_left;
            ctx_o.best   = best_left;
            ctx_o.status = ctx_i.status & ~exc_mask();
        end
    end

    assign word_o = {ctx_i.status, ctx_o.cur};

endmodule

// File: rtl/tpp_event_stage.sv
module tpp_event_stage
    import tpp_pkg::*;
(
    input  ctx_t             ctx_i,
    input  logic             thr_we_i,
    input  logic [CTX_W-1:0] thr_val_i,
    input  logic             post_i,
    input  logic [NPRIO-1:0] post_bits_i,
    output ctx_t             ctx_o,
    output logic             raise_o
);

    logic [NPRIO-1:0] pend_new;
    logic [CTX_W-1:0] best_new;
    logic [CTX_W-1:0] cur_new;
    logic             run_check;

    assign pend_new  = ctx_i.pend | post_bits_i;
    assign cur_new   = thr_we_i ? thr_val_i : ctx_i.cur;
    assign run_check = thr_we_i || post_i;

    tpp_lead_zero #(.N(NPRIO)) u_scan (
        .map_i  (pend_new),
        .best_o (best_new)
    );

    // Strict comparison: an equal priority does not interrupt.
    assign raise_o = run_check && (best_new < cur_new);

    always_comb begin
        ctx_o.pend   = pend_new;
        ctx_o.best   = best_new;
        ctx_o.cur    = cur_new;
        ctx_o.status = raise_o ? (ctx_i.status | exc_mask()) : ctx_i.status;
    end

endmodule

// File: rtl/thread_prio_presenter.sv
module thread_prio_presenter
    import tpp_pkg::*;
#(
    parameter int WDATA_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               evt_valid_i,
    input  logic [CTX_W-1:0]   evt_prio_i,
    input  logic               wr_valid_i,
    input  logic               wr_sel_i,
    input  logic [WDATA_W-1:0] wr_data_i,
    input  logic               ack_req_i,
    output logic               ack_valid_o,
    output logic [ACK_W-1:0]   ack_data_o,
    output logic               irq_o,
    output logic [CTX_W-1:0]   pend_map_o,
    output logic [CTX_W-1:0]   best_prio_o,
    output logic [CTX_W-1:0]   cur_prio_o,
    output logic [CTX_W-1:0]   status_o
);

    ctx_t             ctx_q;
    ctx_t             ctx_acked;
    ctx_t             ctx_next;
    logic             irq_q;
    logic             raise;
    logic             ack_valid_q;
    logic [ACK_W-1:0] ack_data_q;
    logic [ACK_W-1:0] ack_word;

    wsel_e            wsel;
    logic             thr_we;
    logic             post_we;
    logic [NPRIO-1:0] evt_bits;
    logic [NPRIO-1:0] post_bits;
    logic             unused_wr_hi;

    assign wsel    = wsel_e'(wr_sel_i);
    assign thr_we  = wr_valid_i && (wsel == WSEL_THRESH);
    assign post_we = wr_valid_i && (wsel == WSEL_POST);

    if (WDATA_W > CTX_W) begin : g_hi
        assign unused_wr_hi = ^wr_data_i[WDATA_W-1:CTX_W];
    end else begin : g_no_hi
        assign unused_wr_hi = 1'b0;
    end

    // The acknowledge step comes first; the event step sees its result.
    tpp_ack_stage u_ack (
        .ctx_i  (ctx_q),
        .ack_i  (ack_req_i),
        .ctx_o  (ctx_acked),
        .word_o (ack_word)
    );

    tpp_prio_decode #(.N(NPRIO)) u_dec_evt (
        .en_i   (evt_valid_i),
        .prio_i (evt_prio_i),
        .bits_o (evt_bits)
    );

    tpp_prio_decode #(.N(NPRIO)) u_dec_post (
        .en_i   (post_we),
        .prio_i (wr_data_i[CTX_W-1:0]),
        .bits_o (post_bits)
    );

    tpp_event_stage u_evt (
        .ctx_i       (ctx_acked),
        .thr_we_i    (thr_we),
        .thr_val_i   (wr_data_i[CTX_W-1:0]),
        .post_i      (evt_valid_i || post_we),
        .post_bits_i (evt_bits | post_bits),
        .ctx_o       (ctx_next),
        .raise_o     (raise)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q       <= ctx_reset_value();
            irq_q       <= 1'b0;
            ack_valid_q <= 1'b0;
            ack_data_q  <= '0;
        end else begin
            ctx_q       <= ctx_next;
            irq_q       <= raise || (irq_q && !ack_req_i);
            ack_valid_q <= ack_req_i;
            if (ack_req_i) begin
                ack_data_q <= ack_word;
            end
        end
    end

    assign irq_o       = irq_q;
    assign ack_valid_o = ack_valid_q;
    assign ack_data_o  = ack_data_q;
    assign pend_map_o  = ctx_q.pend;
    assign best_prio_o = ctx_q.best;
    assign cur_prio_o  = ctx_q.cur;
    assign status_o    = ctx_q.status;

endmodule

// File: rtl/tpp_checker.sv
module tpp_checker
    import tpp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             evt_valid_i,
    input logic             wr_valid_i,
    input logic             ack_req_i,
    input logic             ack_valid_o,
    input logic [ACK_W-1:0] ack_data_o,
    input logic             irq_o,
    input logic [CTX_W-1:0] pend_map_o,
    input logic [CTX_W-1:0] best_prio_o,
    input logic [CTX_W-1:0] cur_prio_o,
    input logic [CTX_W-1:0] status_o
);

    // R5
    irq_matches_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o == status_o[EXC_BIT]);

    // R3
    empty_map_best_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_map_o == '0) |-> (best_prio_o == NO_PRIO));

    // R3
    best_is_top_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_map_o != '0) |-> (best_prio_o < CTX_W'(NPRIO)
            && pend_map_o[3'd7 - best_prio_o[2:0]]
            && ((pend_map_o >> (CTX_W'(NPRIO) - best_prio_o)) == '0)));

    // R5
    rise_needs_favour_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> (best_prio_o < cur_prio_o));

    // R7
    ack_drops_line_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_req_i && !evt_valid_i && !wr_valid_i) |=> (!irq_o && !status_o[EXC_BIT]));

    // R8
    ack_answer_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ack_req_i |=> ack_valid_o);

    // R8
    ack_answer_thresh_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid_o && !$past(wr_valid_i)) |-> (ack_data_o[CTX_W-1:0] == cur_prio_o));

endmodule

bind thread_prio_presenter tpp_checker u_tpp_checker (
    .clk         (clk),
    .rst         (rst),
    .evt_valid_i (evt_valid_i),
    .wr_valid_i  (wr_valid_i),
    .ack_req_i   (ack_req_i),
    .ack_valid_o (ack_valid_o),
    .ack_data_o  (ack_data_o),
    .irq_o       (irq_o),
    .pend_map_o  (pend_map_o),
    .best_prio_o (best_prio_o),
    .cur_prio_o  (cur_prio_o),
    .status_o    (status_o)
);

// File: tb/test_thread_prio_presenter.sv
module test_thread_prio_presenter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_valid_i = 1'b0;
    logic [7:0]  evt_prio_i = '0;
    logic        wr_valid_i = 1'b0;
    logic        wr_sel_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic        ack_req_i = 1'b0;
    logic        ack_valid_o;
    logic [15:0] ack_data_o;
    logic        irq_o;
    logic [7:0]  pend_map_o, best_prio_o, cur_prio_o, status_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] exp_q[$];
    string       req_q[$];

    logic [7:0] m_pend = 8'h00;
    logic [7:0] m_cur = 8'h00;
    logic [7:0] m_status = 8'h00;
    logic       m_irq = 1'b0;

    always #5 clk = ~clk;

    thread_prio_presenter i_thread_prio_presenter (
        .clk         (clk),
        .rst         (rst),
        .evt_valid_i (evt_valid_i),
        .evt_prio_i  (evt_prio_i),
        .wr_valid_i  (wr_valid_i),
        .wr_sel_i    (wr_sel_i),
        .wr_data_i   (wr_data_i),
        .ack_req_i   (ack_req_i),
        .ack_valid_o (ack_valid_o),
        .ack_data_o  (ack_data_o),
        .irq_o       (irq_o),
        .pend_map_o  (pend_map_o),
        .best_prio_o (best_prio_o),
        .cur_prio_o  (cur_prio_o),
        .status_o    (status_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Spec model: bit for a priority (R2) and favoured priority (R3).
    function automatic logic [7:0] m_bit(input logic [7:0] p);
        return (p < 8) ? (8'h80 >> p) : 8'h00;
    endfunction

    function automatic logic [7:0] m_best(input logic [7:0] map);
        for (int p = 0; p < 8; p++) begin
            if (map[7-p]) return 8'(p);
        end
        return 8'hFF;
    endfunction

    task automatic check_state(input string req);
        chk(req, "pend", {8'h00, pend_map_o}, {8'h00, m_pend});
        chk(req, "best", {8'h00, best_prio_o}, {8'h00, m_best(m_pend)});
        chk(req, "cur", {8'h00, cur_prio_o}, {8'h00, m_cur});
        chk(req, "status", {8'h00, status_o}, {8'h00, m_status});
        chk(req, "irq", {15'h0, irq_o}, {15'h0, m_irq});
    endtask

    // Driver: one cycle of stimulus, starting and ending at a falling edge.
    task automatic step(input string req, input bit ack, input bit evt,
                        input logic [7:0] eprio, input bit wr,
                        input bit sel, input logic [31:0] data);
        logic [7:0] old_status;
        bit touched;
        ack_req_i   = ack;
        evt_valid_i = evt;
        evt_prio_i  = eprio;
        wr_valid_i  = wr;
        wr_sel_i    = sel;
        wr_data_i   = data;
        touched     = 0;
        old_status  = m_status;
        if (ack) begin
            m_irq = 1'b0;
            if (m_status[7]) begin
                m_cur = m_best(m_pend);
                m_pend = m_pend & ~m_bit(m_cur);
                m_status[7] = 1'b0;
            end
            exp_q.push_back({old_status, m_cur});
            req_q.push_back(req);
        end
        if (wr && !sel) begin
            m_cur = data[7:0];
            touched = 1;
        end
        if (wr && sel) begin
            m_pend = m_pend | m_bit(data[7:0]);
            touched = 1;
        end
        if (evt) begin
            m_pend = m_pend | m_bit(eprio);
            touched = 1;
        end
        if (touched && (m_best(m_pend) < m_cur)) begin
            m_status[7] = 1'b1;
            m_irq = 1'b1;
        end
        @(negedge clk);
        ack_req_i   = 0;
        evt_valid_i = 0;
        wr_valid_i  = 0;
        check_state(req);
    endtask

    // Monitor: pops the expected acknowledge answer when one appears.
    always @(negedge clk) begin
        if (!rst && ack_valid_o) begin
            if (exp_q.size() == 0) begin
                chk("R8", "unexpected ack", ack_data_o, 16'hxxxx);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string r = req_q.pop_front();
                chk({r, "/R8"}, "ack word", ack_data_o, e);
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check_state("R1");
        chk("R1", "ack_valid", {15'h0, ack_valid_o}, 16'h0);

        // R2 R3 R5: priority 3 against threshold 0 -> bit 4, no interrupt
        step("R5", 0, 1, 8'd3, 0, 0, 32'h0);
        chk("R2", "bit of prio 3", {8'h00, pend_map_o}, 16'h0010);
        // R5 strict: threshold equal to pending priority
        step("R5", 0, 0, 8'd0, 1, 0, 32'h0000_0003);
        chk("R5", "equal no irq", {15'h0, irq_o}, 16'h0);
        // R6 less restrictive threshold raises
        step("R6", 0, 0, 8'd0, 1, 0, 32'h0000_0004);
        chk("R6", "irq raised", {15'h0, irq_o}, 16'h1);
        // R7 acknowledge with exception active
        step("R7", 1, 0, 8'd0, 0, 0, 32'h0);
        chk("R7", "threshold promoted", {8'h00, cur_prio_o}, 16'h0003);
        // R7 acknowledge with no exception: no change
        step("R7", 1, 0, 8'd0, 0, 0, 32'h0);
        // R4 set-pending with upper data bits set, low byte 5
        step("R4", 0, 0, 8'd0, 1, 1, 32'hABCD_0105);
        chk("R4", "low byte only", {8'h00, pend_map_o}, 16'h0004);
        // R2 out-of-range priority sets nothing
        step("R2", 0, 1, 8'd9, 0, 0, 32'h0);
        step("R2", 0, 1, 8'hFF, 0, 0, 32'h0);
        // R4 notify priority 1 below threshold 3
        step("R4", 0, 1, 8'd1, 0, 0, 32'h0);
        // R9 acknowledge together with notify priority 0
        step("R9", 1, 1, 8'd0, 0, 0, 32'h0);
        chk("R9", "re-raised", {15'h0, irq_o}, 16'h1);
        // R6 threshold 0xFF while flagged, then acknowledge
        step("R6", 0, 0, 8'd0, 1, 0, 32'h0000_00FF);
        step("R7", 1, 0, 8'd0, 0, 0, 32'h0);
        // R9 acknowledge (no exception) with threshold write 7
        step("R9", 1, 0, 8'd0, 1, 0, 32'h0000_0007);
        // R4 notify and set-pending in one cycle
        step("R4", 0, 1, 8'd7, 1, 1, 32'h0000_0006);
        chk("R4", "both posted", {8'h00, pend_map_o}, 16'h0007);
        step("R7", 1, 0, 8'd0, 0, 0, 32'h0);
        // R3 drain remaining priorities with low thresholds
        step("R3", 0, 0, 8'd0, 1, 0, 32'h0000_0008);
        step("R3", 1, 0, 8'd0, 0, 0, 32'h0);
        step("R3", 0, 0, 8'd0, 1, 0, 32'h0000_0008);
        step("R3", 1, 0, 8'd0, 0, 0, 32'h0);
        step("R3", 0, 0, 8'd0, 1, 0, 32'h0000_0008);
        step("R3", 1, 0, 8'd0, 0, 0, 32'h0);
        chk("R3", "empty best", {8'h00, best_prio_o}, 16'h00FF);
        step("R8", 0, 0, 8'd0, 0, 0, 32'h0);
        chk("R8", "all answers seen", 16'(exp_q.size()), 16'h0);
        done = 1;
        finish_run();
    end

endmodule